// File: doc/BRIEF.md
# Dual-Channel Transfer Interval Counter

This block paces interrupts for a streaming audio path that has a playback direction and a capture direction. Software programs, for each direction, a 16-bit interval value through a pair of byte-wide registers. A down-counter per direction starts from that value. It steps once for every transfer the data mover reports. When it passes below zero it raises that direction's interrupt flag and reloads itself, so interrupts keep arriving at a fixed interval with no further software action. The global interrupt output is high while either flag is set.

The unit of one step depends on the data format. For plain sample formats it is one sample, whether the sample is mono or stereo and whether it is 8 or 16 bits wide. For the packed 4-bit ADPCM format it is one 4-byte word. Software therefore programs samples minus one, or bytes divided by four minus one. In the single-direction mode, or when the shared-counter control is set, the playback counter counts the transfers of both directions, and the capture flag stays clear.

Top module: `dma_xfer_count`

## Requirements
- R1: After reset every readable register is zero and irqOut is 0. The interval registers read back at regAddr 0 (playback low byte), 1 (playback high byte), 2 (capture low byte) and 3 (capture high byte). Each interval value is {high, low}.
- R2: When a channel's ADPCM input is 0, each cycle with that channel's sample strobe high counts one transfer, and its word strobe is ignored. With interval N, the flag sets on the N+1th counted transfer.
- R3: When a channel's ADPCM input is 1, each cycle with its word strobe high counts one transfer, and its sample strobe is ignored.
- R4: A playback underflow sets flag bit 0 at regAddr 4, drives irqOut to 1 and sets bit 0 at regAddr 5 one cycle after the strobe. The counter reloads, so the next flag follows after another N+1 transfers.
- R5: With fullDuplex=1 and sharedCnt=0, capture transfers count on a separate capture counter, and its underflow sets flag bit 1 at regAddr 4 and irqOut.
- R6: A write of any value to regAddr 5 clears both flags. A write to regAddr 4 clears each flag whose data bit is 0 and leaves any flag whose data bit is 1 unchanged.
- R7: With fullDuplex=0 or sharedCnt=1, capture transfers step the playback counter and flag bit 1 never sets. A playback transfer and a capture transfer in the same cycle step it once.
- R8: When an underflow and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R9: Writing either byte of an interval register loads that channel's counter with the new 16-bit value. This load takes priority over a transfer in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address for read and write |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for regAddr (combinational) |
| fullDuplex | input | 1 | 1 = two independent counters allowed |
| sharedCnt | input | 1 | 1 = playback counter serves both directions |
| playAdpcm | input | 1 | Playback counts 4-byte words |
| capAdpcm | input | 1 | Capture counts 4-byte words |
| playSampleStb | input | 1 | One playback sample transferred |
| playWordStb | input | 1 | One playback 4-byte word transferred |
| capSampleStb | input | 1 | One capture sample transferred |
| capWordStb | input | 1 | One capture 4-byte word transferred |
| irqOut | output | 1 | Global interrupt, OR of the two flags |

## Verification
The two functions that can collide are a counter underflow setting a flag and a register write clearing that same flag. An interval write can also coincide with a transfer strobe. The bench provokes both by issuing the write in the very cycle the strobe that exhausts or steps the counter arrives. It then judges the result from the flags register and irqOut one cycle later: the flag must be set, and the counter must restart from the written value. A behavioural model checks every cycle's read data and irqOut against its own counters.

// File: rtl/dmacnt_pkg.sv
package dmacnt_pkg;
  localparam int ADDR_W = 3;
  localparam int NUM_CH = 2;

  localparam logic [ADDR_W-1:0] A_PLAY_LO = 3'd0;
  localparam logic [ADDR_W-1:0] A_PLAY_HI = 3'd1;
  localparam logic [ADDR_W-1:0] A_CAP_LO  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CAP_HI  = 3'd3;
  localparam logic [ADDR_W-1:0] A_FLAGS   = 3'd4;
  localparam logic [ADDR_W-1:0] A_STATUS  = 3'd5;

  // index 0 = playback, index 1 = capture
  typedef struct packed {
    logic [NUM_CH-1:0] loadLo;
    logic [NUM_CH-1:0] loadHi;
    logic [NUM_CH-1:0] dec;
    logic [NUM_CH-1:0] clr;
  } ctlStrobes_t;
endpackage

// File: rtl/dmacnt_ctrl.sv
module dmacnt_ctrl
  import dmacnt_pkg::*;
(
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [NUM_CH-1:0] flagBits,
  input  logic              fullDuplex,
  input  logic              sharedCnt,
  input  logic [NUM_CH-1:0] adpcmMode,
  input  logic [NUM_CH-1:0] sampleStb,
  input  logic [NUM_CH-1:0] wordStb,
  output ctlStrobes_t       strobes
);
  logic [NUM_CH-1:0] xferEv;
  logic              sharedMode;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ev
    assign xferEv[ch] = adpcmMode[ch] ? wordStb[ch] : sampleStb[ch];
  end

  assign sharedMode = !fullDuplex || sharedCnt;

  always_comb begin
    strobes.dec[0]    = xferEv[0] | (sharedMode & xferEv[1]);
    strobes.dec[1]    = ~sharedMode & xferEv[1];
    strobes.loadLo[0] = regWrEn && (regAddr == A_PLAY_LO);
    strobes.loadHi[0] = regWrEn && (regAddr == A_PLAY_HI);
    strobes.loadLo[1] = regWrEn && (regAddr == A_CAP_LO);
    strobes.loadHi[1] = regWrEn && (regAddr == A_CAP_HI);
    for (int ch = 0; ch < NUM_CH; ch++) begin
      strobes.clr[ch] = regWrEn &&
        ((regAddr == A_STATUS) || ((regAddr == A_FLAGS) && !flagBits[ch]));
    end
  end
endmodule

// File: rtl/dmacnt_chan.sv
module dmacnt_chan #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadLo,
  input  logic              loadHi,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              dec,
  input  logic              clr,
  output logic [2*BYTE_W-1:0] base,
  output logic              flag
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] baseLo, baseHi;
  logic [CNT_W-1:0]  cnt, nextBase;
  logic              anyLoad, underflow;

  assign base      = {baseHi, baseLo};
  assign nextBase  = {loadHi ? wrData : baseHi, loadLo ? wrData : baseLo};
  assign anyLoad   = loadLo || loadHi;
  assign underflow = dec && !anyLoad && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseLo <= '0;
      baseHi <= '0;
      cnt    <= '0;
      flag   <= 1'b0;
    end else begin
      baseLo <= nextBase[BYTE_W-1:0];
      baseHi <= nextBase[CNT_W-1:BYTE_W];
      if (anyLoad)        cnt <= nextBase;
      else if (underflow) cnt <= base;
      else if (dec)       cnt <= cnt - 1'b1;
      if (underflow)      flag <= 1'b1;
      else if (clr)       flag <= 1'b0;
    end
  end

  AST_UNDERFLOW_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (dec && !anyLoad && cnt == '0) |=> flag); // R4
  AST_UNDERFLOW_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    (dec && !anyLoad && cnt == '0) |=> (cnt == base)); // R4
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (dec && !anyLoad && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R2
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (dec && !anyLoad && cnt == '0 && clr) |=> flag); // R8
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rstN)
    anyLoad |=> (cnt == base)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!dec && !anyLoad) |=> $stable(cnt)); // R2
endmodule

// File: rtl/dmacnt_datapath.sv
module dmacnt_datapath
  import dmacnt_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [BYTE_W-1:0] regWrData,
  input  logic [ADDR_W-1:0] regAddr,
  output logic [BYTE_W-1:0] regRdData,
  output logic [NUM_CH-1:0] flags,
  output logic              irqOut
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [CNT_W-1:0] chBase [NUM_CH];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    dmacnt_chan #(.BYTE_W(BYTE_W)) i_chan (
      .clk    (clk),
      .rstN   (rstN),
      .loadLo (strobes.loadLo[ch]),
      .loadHi (strobes.loadHi[ch]),
      .wrData (regWrData),
      .dec    (strobes.dec[ch]),
      .clr    (strobes.clr[ch]),
      .base   (chBase[ch]),
      .flag   (flags[ch])
    );
  end

  assign irqOut = |flags;

  always_comb begin
    case (regAddr)
      A_PLAY_LO: regRdData = chBase[0][BYTE_W-1:0];
      A_PLAY_HI: regRdData = chBase[0][CNT_W-1:BYTE_W];
      A_CAP_LO:  regRdData = chBase[1][BYTE_W-1:0];
      A_CAP_HI:  regRdData = chBase[1][CNT_W-1:BYTE_W];
      A_FLAGS:   regRdData = BYTE_W'(flags);
      A_STATUS:  regRdData = BYTE_W'(irqOut);
      default:   regRdData = '0;
    endcase
  end
endmodule

// File: rtl/dma_xfer_count.sv
module dma_xfer_count
  import dmacnt_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BYTE_W-1:0] regWrData,
  output logic [BYTE_W-1:0] regRdData,
  input  logic              fullDuplex,
  input  logic              sharedCnt,
  input  logic              playAdpcm,
  input  logic              capAdpcm,
  input  logic              playSampleStb,
  input  logic              playWordStb,
  input  logic              capSampleStb,
  input  logic              capWordStb,
  output logic              irqOut
);
  ctlStrobes_t       strobes;
  logic [NUM_CH-1:0] flags;

  dmacnt_ctrl i_ctrl (
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .flagBits   (regWrData[NUM_CH-1:0]),
    .fullDuplex (fullDuplex),
    .sharedCnt  (sharedCnt),
    .adpcmMode  ({capAdpcm, playAdpcm}),
    .sampleStb  ({capSampleStb, playSampleStb}),
    .wordStb    ({capWordStb, playWordStb}),
    .strobes    (strobes)
  );

  dmacnt_datapath #(.BYTE_W(BYTE_W)) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .regWrData (regWrData),
    .regAddr   (regAddr),
    .regRdData (regRdData),
    .flags     (flags),
    .irqOut    (irqOut)
  );

  AST_SHARED_CAP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ((!fullDuplex || sharedCnt) && !flags[1]) |=> !flags[1]); // R7
  AST_STATUS_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == A_STATUS && !strobes.dec[0] && !strobes.dec[1])
      |=> (flags == '0)); // R6
endmodule

// File: tb/test_dma_xfer_count.sv
`timescale 1ns/1ps
module test_dma_xfer_count;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       fullDuplex = 1'b1, sharedCnt = 1'b0;
  logic       playAdpcm = 1'b0, capAdpcm = 1'b0;
  logic       playSampleStb = 1'b0, playWordStb = 1'b0;
  logic       capSampleStb = 1'b0, capWordStb = 1'b0;
  logic       irqOut;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;

  // behavioural reference model
  int mBase [2];
  int mCnt  [2];
  bit mFlag [2];

  always #2.5 clk = ~clk;

  dma_xfer_count i_dma_xfer_count (
    .clk, .rstN, .regWrEn, .regAddr, .regWrData, .regRdData,
    .fullDuplex, .sharedCnt, .playAdpcm, .capAdpcm,
    .playSampleStb, .playWordStb, .capSampleStb, .capWordStb, .irqOut
  );

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int modelRead(int a);
    case (a)
      0: return mBase[0] & 8'hff;
      1: return (mBase[0] >> 8) & 8'hff;
      2: return mBase[1] & 8'hff;
      3: return (mBase[1] >> 8) & 8'hff;
      4: return {30'd0, mFlag[1], mFlag[0]};
      5: return (mFlag[0] || mFlag[1]) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int ch = 0; ch < 2; ch++) begin
        mBase[ch] = 0; mCnt[ch] = 0; mFlag[ch] = 0;
      end
    end else begin
      bit shared, pe, ce;
      bit dec [2];
      shared = !fullDuplex || sharedCnt;
      pe = playAdpcm ? playWordStb : playSampleStb;
      ce = capAdpcm ? capWordStb : capSampleStb;
      dec[0] = pe || (shared && ce);
      dec[1] = !shared && ce;
      for (int ch = 0; ch < 2; ch++) begin
        bit setF, clrF, wrLo, wrHi;
        setF = 0;
        wrLo = regWrEn && (regAddr == 3'(2*ch));
        wrHi = regWrEn && (regAddr == 3'(2*ch+1));
        if (wrLo) mBase[ch] = (mBase[ch] & 16'hff00) | regWrData;
        if (wrHi) mBase[ch] = (mBase[ch] & 16'h00ff) | (int'(regWrData) << 8);
        if (wrLo || wrHi) mCnt[ch] = mBase[ch];
        else if (dec[ch]) begin
          if (mCnt[ch] == 0) begin setF = 1; mCnt[ch] = mBase[ch]; end
          else mCnt[ch]--;
        end
        clrF = regWrEn && (regAddr == 3'd5 || (regAddr == 3'd4 && !regWrData[ch]));
        if (setF) mFlag[ch] = 1;
        else if (clrF) mFlag[ch] = 0;
      end
    end
  end

  // every-cycle comparison against the model
  always @(posedge clk) begin
    #1;
    if (rstN && !finished) begin
      check("R4 irq model", irqOut, (mFlag[0] || mFlag[1]) ? 1 : 0);
      check(regAddr == 3'd4 ? "R6 flags model" : "R1 read model",
            regRdData, modelRead(regAddr));
    end
  end

  task automatic cyc(bit wr, int a, int d, bit ps, bit pw, bit cs, bit cw);
    regWrEn = wr; regAddr = 3'(a); regWrData = 8'(d);
    playSampleStb = ps; playWordStb = pw; capSampleStb = cs; capWordStb = cw;
    @(negedge clk);
    regWrEn = 0; playSampleStb = 0; playWordStb = 0; capSampleStb = 0; capWordStb = 0;
  endtask

  task automatic wr(int a, int d);
    cyc(1, a, d, 0, 0, 0, 0);
  endtask

  task automatic rd(int a, output int v);
    regAddr = 3'(a);
    #1;
    v = regRdData;
  endtask

  int v;

  initial begin
    #(5.0 * 100000);
    nErrors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(a, v); check("R1 reset read", v, 0);
    end
    check("R1 reset irq", irqOut, 0);

    // R1 readback, R2 sample counting
    wr(0, 3); wr(1, 0);
    rd(0, v); check("R1 play low", v, 3);
    rd(1, v); check("R1 play high", v, 0);
    repeat (3) cyc(0, 4, 0, 1, 0, 0, 0);
    cyc(0, 4, 0, 0, 1, 0, 0); // word strobe ignored in sample format
    rd(4, v); check("R2 no flag before N+1", v, 0);
    cyc(0, 4, 0, 1, 0, 0, 0);
    rd(4, v); check("R2 flag on N+1th sample", v, 1);
    check("R4 irq high", irqOut, 1);
    rd(5, v); check("R4 status bit", v, 1);

    // R6 status write clears, R4 reload
    wr(5, 8'ha5);
    rd(4, v); check("R6 status write clears", v, 0);
    repeat (3) cyc(0, 4, 0, 1, 0, 0, 0);
    rd(4, v); check("R4 reload no early flag", v, 0);
    cyc(0, 4, 0, 1, 0, 0, 0);
    rd(4, v); check("R4 flag repeats after reload", v, 1);
    wr(4, 8'h02);
    rd(4, v); check("R6 flags bit0 write 0 clears", v, 0);

    // R3 ADPCM word counting
    playAdpcm = 1;
    wr(0, 1);
    repeat (5) cyc(0, 4, 0, 1, 0, 0, 0);
    rd(4, v); check("R3 samples ignored", v, 0);
    cyc(0, 4, 0, 0, 1, 0, 0);
    rd(4, v); check("R3 one word not enough", v, 0);
    cyc(0, 4, 0, 0, 1, 0, 0);
    rd(4, v); check("R3 flag on second word", v, 1);
    playAdpcm = 0;

    // R5 independent capture counter
    wr(2, 2); wr(3, 0);
    rd(2, v); check("R5 cap low readback", v, 2);
    rd(3, v); check("R5 cap high readback", v, 0);
    repeat (2) cyc(0, 4, 0, 0, 0, 1, 0);
    rd(4, v); check("R5 cap not yet", v, 1);
    cyc(0, 4, 0, 0, 0, 1, 0);
    rd(4, v); check("R5 cap flag set", v, 3);
    wr(4, 8'h01);
    rd(4, v); check("R6 bit1 cleared, bit0 kept", v, 1);
    wr(5, 0);

    // R7 shared counter
    sharedCnt = 1;
    wr(0, 2);
    cyc(0, 4, 0, 1, 0, 1, 0); // both in same cycle count once
    cyc(0, 4, 0, 0, 0, 1, 0);
    rd(4, v); check("R7 same-cycle counts once", v, 0);
    cyc(0, 4, 0, 0, 0, 1, 0);
    rd(4, v); check("R7 capture steps playback counter", v, 1);
    sharedCnt = 0; fullDuplex = 0;
    wr(5, 0);
    repeat (3) cyc(0, 4, 0, 0, 0, 1, 0);
    rd(4, v); check("R7 single mode shares counter", v, 1);
    fullDuplex = 1;
    wr(5, 0);

    // R8 set beats clear
    wr(0, 0);
    cyc(1, 5, 0, 1, 0, 0, 0);
    rd(4, v); check("R8 set wins over status clear", v, 1);
    wr(5, 0);

    // R9 base write loads counter and beats a strobe
    wr(0, 5);
    repeat (2) cyc(0, 4, 0, 1, 0, 0, 0);
    cyc(1, 0, 1, 1, 0, 0, 0);
    cyc(0, 4, 0, 1, 0, 0, 0);
    rd(4, v); check("R9 reloaded value counts from 1", v, 0);
    cyc(0, 4, 0, 1, 0, 0, 0);
    rd(4, v); check("R9 flag after new interval", v, 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule